// File: doc/BRIEF.md
# Priority Shift Register

This block is a parameterised register (four bits by default). It can hold its value, take a parallel word, or shift one place in either direction, with a serial bit entering at the vacated end. Three independent active-high request lines select the operation: load, shift right and shift left. A fixed priority resolves them when more than one is high, so the requester does not need to keep them mutually exclusive. Load beats shift right, and shift right beats shift left.

A small combinational encoder turns the three requests into a 2-bit operation code:

| Code | Operation |
|------|-----------|
| 00 | hold |
| 01 | load |
| 10 | shift right |
| 11 | shift left |

Each bit slice uses this code to steer a four-way selector in front of its flip-flop. The register contents are always visible on the parallel output. Every change takes place on the rising clock edge, and a synchronous reset clears the register.

The encoder has four named outcomes:

- OP_HOLD, when no request is high.
- OP_LOAD, when load is high.
- OP_SHR, when shift right is high and load is low.
- OP_SHL, when only shift left is high.

Top module: `prio_shift_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `q_out` reads all zeros after that edge, whatever the request lines are.
- R2: When `ld_req` is high at an edge (reset low), `q_out` equals the `d_in` sampled at that edge, whatever `shr_req` and `shl_req` are.
- R3: When `ld_req` is low and both `shr_req` and `shl_req` are high, the register shifts right and does not shift left.
- R4: A right shift moves bit i+1 into bit i for every i below the top bit, and puts `shr_bit` into the top bit (bit WIDTH-1).
- R5: When `shl_req` alone is high, bit i-1 moves into bit i for every i above 0, and `shl_bit` goes into bit 0.
- R6: With all three requests low, `q_out` keeps its value, and `d_in`, `shr_bit` and `shl_bit` have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_req | input | 1 | Parallel load request (highest priority) |
| shr_req | input | 1 | Shift toward bit 0 |
| shl_req | input | 1 | Shift toward the top bit (lowest priority) |
| shr_bit | input | 1 | Serial bit that enters the top bit on a right shift |
| shl_bit | input | 1 | Serial bit that enters bit 0 on a left shift |
| d_in | input | WIDTH | Parallel data word |
| q_out | output | WIDTH | Register contents |

## Verification
The properties assume that every input is a known 0 or 1 at each sampling edge, and that reset has been applied at least once before any check is armed. The bench meets both conditions. It holds reset high from time zero and drives every input on the falling clock edge, so values are stable and defined when the rising edge samples them. Every start value is swept against every request combination, every pair of serial bits and every data word. The expected result is computed with shifts and masks on the start value.

// File: rtl/psr_pkg.sv
package psr_pkg;
    typedef enum logic [1:0] {
        OP_HOLD = 2'b00,
        OP_LOAD = 2'b01,
        OP_SHR  = 2'b10,
        OP_SHL  = 2'b11
    } op_e;
endpackage

// File: rtl/psr_sel_enc.sv
module psr_sel_enc
    import psr_pkg::*;
(
    input  logic ld_req,
    input  logic shr_req,
    input  logic shl_req,
    output op_e  op
);
    // Fixed priority: load, then right, then left.
    always_comb begin
        unique casez ({ld_req, shr_req, shl_req})
            3'b1??:  op = OP_LOAD;
            3'b01?:  op = OP_SHR;
            3'b001:  op = OP_SHL;
            default: op = OP_HOLD;
        endcase
    end
endmodule

// File: rtl/psr_cell.sv
module psr_cell
    import psr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  logic load_bit,
    input  logic from_hi,
    input  logic from_lo,
    output logic q
);
    logic nxt;

    always_comb begin
        unique case (op)
            OP_HOLD: nxt = q;
            OP_LOAD: nxt = load_bit;
            OP_SHR:  nxt = from_hi;
            OP_SHL:  nxt = from_lo;
            default: nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt;
    end
endmodule

// File: rtl/prio_shift_reg.sv
module prio_shift_reg
    import psr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_req,
    input  logic             shr_req,
    input  logic             shl_req,
    input  logic             shr_bit,
    input  logic             shl_bit,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    localparam int TOP = WIDTH - 1;

    op_e op;

    psr_sel_enc u_enc (
        .ld_req  (ld_req),
        .shr_req (shr_req),
        .shl_req (shl_req),
        .op      (op)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic hi_src;
        logic lo_src;
        if (i == TOP) begin : g_top
            assign hi_src = shr_bit;
        end else begin : g_mid_hi
            assign hi_src = q_out[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_src = shl_bit;
        end else begin : g_mid_lo
            assign lo_src = q_out[i-1];
        end
        psr_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .op       (op),
            .load_bit (d_in[i]),
            .from_hi  (hi_src),
            .from_lo  (lo_src),
            .q        (q_out[i])
        );
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> q_out == '0); // R1
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_req |=> q_out == $past(d_in)); // R2
    AST_RIGHT_OVER_LEFT: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && shr_req && shl_req) |=> q_out == {$past(shr_bit), $past(q_out[TOP:1])}); // R3
    AST_SHIFT_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && shr_req) |=> q_out == {$past(shr_bit), $past(q_out[TOP:1])}); // R4
    AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && !shr_req && shl_req) |=> q_out == {$past(q_out[TOP-1:0]), $past(shl_bit)}); // R5
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!ld_req && !shr_req && !shl_req) |=> $stable(q_out)); // R6
endmodule

// File: tb/test_prio_shift_reg.sv
module test_prio_shift_reg;
    localparam int W = 4;
    localparam int MAXV = 1 << W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_req = 1'b0, shr_req = 1'b0, shl_req = 1'b0;
    logic shr_bit = 1'b0, shl_bit = 1'b0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q_out;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    prio_shift_reg #(.WIDTH(W)) i_prio_shift_reg (
        .clk(clk), .rst(rst), .ld_req(ld_req), .shr_req(shr_req),
        .shl_req(shl_req), .shr_bit(shr_bit), .shl_bit(shl_bit),
        .d_in(d_in), .q_out(q_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive on the falling edge; the rising edge falls between two calls.
    task automatic step(input logic l, input logic r, input logic s,
                        input logic sr, input logic sl, input logic [W-1:0] d);
        @(negedge clk);
        ld_req = l; shr_req = r; shl_req = s;
        shr_bit = sr; shl_bit = sl; d_in = d;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [W-1:0] exp;
        string tag;
        rst = 1'b1;
        step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, '1);
        check("R1 reset beats load", q_out, '0);
        rst = 1'b0;

        for (int st = 0; st < MAXV; st++) begin
            for (int ctl = 0; ctl < 8; ctl++) begin
                for (int ser = 0; ser < 4; ser++) begin
                    for (int pv = 0; pv < MAXV; pv++) begin
                        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, W'(st));
                        step(ctl[2], ctl[1], ctl[0], ser[1], ser[0], W'(pv));
                        if (ctl[2]) begin
                            exp = W'(pv); tag = "R2 load priority";
                        end else if (ctl[1]) begin
                            exp = W'((st >> 1) | (ser[1] << (W-1)));
                            tag = ctl[0] ? "R3 right over left" : "R4 shift right";
                        end else if (ctl[0]) begin
                            exp = W'((st << 1) | ser[0]);
                            tag = "R5 shift left";
                        end else begin
                            exp = W'(st); tag = "R6 hold";
                        end
                        check(tag, q_out, exp);
                    end
                end
            end
        end

        // R6: a second hold cycle with noisy inputs keeps the value.
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, W'(4'b1010));
        step(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, W'(4'b0101));
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, W'(4'b1111));
        check("R6 repeated hold", q_out, W'(4'b1010));

        rst = 1'b1;
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, '0);
        check("R1 reset beats shift", q_out, '0);
        rst = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule